// File: doc/BRIEF.md
# Serial-Load Register with Held Parallel Outputs

This block collects a serial bit stream into a chain of shift stages. On command it copies the whole chain into a separate holding register, which drives a parallel output word. Shifting and copying are separate commands. New bits can therefore stream into the chain while the parallel word stays steady, and the word changes in one step only when the copy command arrives. The last shift stage is also driven out as a serial cascade output, so that several blocks can be chained into a longer register.

The block runs on one system clock. Each "clock edge" of the serial interface is given as a one-cycle strobe: `shift_i` stands for one shift-clock rising edge and `store_i` for one storage-clock rising edge. An active-low asynchronous reset clears the shift stages only and leaves the holding register alone. The parallel side is meant for use inside a chip. It appears as a data vector plus an enable flag, and an active-low output enable controls both. The serial cascade output is never gated by the output enable.

Top module: `ser_par_latch`

## Requirements
- R1: In a cycle with `shift_i` high, stage A (bit 0) takes `ser_i` at the clock edge and each stage k+1 takes the old value of stage k.
- R2: In a cycle with `shift_i` low, the shift stages keep their values.
- R3: In a cycle with `store_i` high, the holding register takes a copy of all shift stages at the clock edge. In a cycle with `store_i` low it keeps its value, even when `shift_i` is high.
- R4: While `rst_ni` is low, all shift stages are zero and `ser_o` is low. This takes effect at once, without a clock edge.
- R5: Reset does not change the holding register.
- R6: With `oe_ni` low, `par_o` equals the holding register (bit 0 = stage A copy) and `par_oe_o` is 1. With `oe_ni` high, `par_o` is all zeros and `par_oe_o` is 0.
- R7: `ser_o` always equals the last stage H (bit WIDTH-1), whatever the value of `oe_ni`.
- R8: When `shift_i` and `store_i` are high in the same cycle, the holding register takes the stage contents from before that shift.
- R9: After reset is released, the first shift puts `ser_i` into stage A and leaves every other stage zero.
- R10: With two blocks chained (`ser_o` of the first block into `ser_i` of the second) and driven by common strobes, 16 shifts move a 16-bit word through both blocks. The first bit sent ends in stage H of the second block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the shift stages |
| ser_i | input | 1 | Serial data in |
| shift_i | input | 1 | One shift edge per high cycle |
| store_i | input | 1 | One storage edge per high cycle |
| oe_ni | input | 1 | Active-low parallel output enable |
| par_o | output | WIDTH | Parallel data, zero when disabled |
| par_oe_o | output | 1 | Parallel drive enable flag |
| ser_o | output | 1 | Serial cascade output (stage H) |

## Verification
The hardest case to reach from the ports is a reset that lands between clock edges while the holding register contains a known non-zero word. The bench first loads a pattern, copies it into the holding register and starts a new pattern shifting in. It then drops `rst_ni` in the middle of a clock period. At that point it checks `ser_o` before any edge arrives. After release it reads the holding register back through `par_o`, which shows that reset left it untouched. The same-cycle shift-and-store case is reached by raising both strobes together after a known pattern has been loaded. The bench then compares the parallel word against the contents from before the shift.

// File: rtl/ser_par_latch_pkg.sv
package ser_par_latch_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  function automatic logic [DEF_WIDTH-1:0] rev_bits(input logic [DEF_WIDTH-1:0] v);
    for (int i = 0; i < DEF_WIDTH; i++) rev_bits[i] = v[DEF_WIDTH-1-i];
  endfunction
endpackage

// File: rtl/ser_par_latch_chain.sv
module ser_par_latch_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             shift_i,
  output logic [WIDTH-1:0] stage_o
);
  logic [WIDTH-1:0] stage_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic d;
    if (k == 0) begin : g_head
      assign d = ser_i;
    end else begin : g_body
      assign d = stage_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[k] <= 1'b0;
      else if (shift_i) stage_q[k] <= d;
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/ser_par_latch_hold.sv
module ser_par_latch_hold #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             store_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // no reset by intent: contents survive shift-stage reset
  logic [WIDTH-1:0] q;
  always_ff @(posedge clk_i) begin
    if (store_i) q <= d_i;
  end
  assign q_o = q;
endmodule

// File: rtl/ser_par_latch_gate.sv
module ser_par_latch_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] par_o,
  output logic             par_oe_o
);
  logic en;
  assign en       = ~oe_ni;
  assign par_oe_o = en;
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign par_o[k] = d_i[k] & en;
  end
endmodule

// File: rtl/ser_par_latch.sv
module ser_par_latch
  import ser_par_latch_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             shift_i,
  input  logic             store_i,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] par_o,
  output logic             par_oe_o,
  output logic             ser_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;

  ser_par_latch_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ser_i   (ser_i),
    .shift_i (shift_i),
    .stage_o (shift_q)
  );

  ser_par_latch_hold #(.WIDTH(WIDTH)) u_hold (
    .clk_i   (clk_i),
    .store_i (store_i),
    .d_i     (shift_q),
    .q_o     (hold_q)
  );

  ser_par_latch_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_ni    (oe_ni),
    .d_i      (hold_q),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  assign ser_o = shift_q[LAST];
endmodule

// File: rtl/ser_par_latch_chk.sv
module ser_par_latch_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_i,
  input logic             shift_i,
  input logic             store_i,
  input logic             oe_ni,
  input logic [WIDTH-1:0] par_o,
  input logic             par_oe_o,
  input logic             ser_o,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] hold_q
);
  logic held_valid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_valid_q <= 1'b0;
    else if (store_i) held_valid_q <= 1'b1;
  end

  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_i)}); // R1
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(shift_q)); // R2
  AST_STORE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> hold_q == $past(shift_q)); // R3 R8
  AST_STORE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_valid_q && !store_i) |=> hold_q == $past(hold_q)); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (par_o == '0 && !par_oe_o)); // R6
  AST_ENABLED_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && held_valid_q) |-> (par_oe_o && par_o == hold_q)); // R6
  AST_SER_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> ser_o == $past(shift_q[WIDTH-2])); // R7

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEARS: assert (shift_q == '0 && !ser_o); // R4
    end
  end
endmodule

bind ser_par_latch ser_par_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ser_i    (ser_i),
  .shift_i  (shift_i),
  .store_i  (store_i),
  .oe_ni    (oe_ni),
  .par_o    (par_o),
  .par_oe_o (par_oe_o),
  .ser_o    (ser_o),
  .shift_q  (shift_q),
  .hold_q   (hold_q)
);

// File: tb/ser_par_latch_bench.sv
module ser_par_latch_bench;
  localparam int W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_i = 1'b0, shift_i = 1'b0, store_i = 1'b0, oe_ni = 1'b0;
  logic rst_b = 1'b0;
  logic [W-1:0] par_o, par_b;
  logic par_oe_o, par_oe_b, ser_o, ser_b;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  ser_par_latch #(.WIDTH(W)) u_ser_par_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .shift_i(shift_i),
    .store_i(store_i), .oe_ni(oe_ni), .par_o(par_o), .par_oe_o(par_oe_o),
    .ser_o(ser_o)
  );

  ser_par_latch #(.WIDTH(W)) u_ser_par_latch_b (
    .clk_i(clk_i), .rst_ni(rst_b), .ser_i(ser_o), .shift_i(shift_i),
    .store_i(store_i), .oe_ni(oe_ni), .par_o(par_b), .par_oe_o(par_oe_b),
    .ser_o(ser_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one system cycle: strobes high across one rising edge, then sample
  task automatic step(input logic s, input logic sh, input logic st);
    @(negedge clk_i);
    ser_i = s; shift_i = sh; store_i = st;
    @(posedge clk_i);
    #2;
    shift_i = 1'b0; store_i = 1'b0;
  endtask

  // first bit sent is v[W-1], so after W shifts stage k holds v[k]
  task automatic shift_word(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) step(v[i], 1'b1, 1'b0);
  endtask

  task automatic t_reset_state;
    check("R4 ser_o in reset", {31'b0, ser_o}, 32'd0);
    check("R4 cascade ser in reset", {31'b0, ser_b}, 32'd0);
  endtask

  task automatic t_first_shift;
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    check("R9 first shift", {24'b0, par_o}, 32'h01);
    check("R6 enabled flag", {31'b0, par_oe_o}, 32'd1);
  endtask

  task automatic t_shift_store(input logic [W-1:0] v);
    shift_word(v);
    check("R7 ser_o is stage H", {31'b0, ser_o}, {31'b0, v[W-1]});
    step(1'b0, 1'b0, 1'b1);
    check("R1 R3 stored word", {24'b0, par_o}, {24'b0, v});
  endtask

  task automatic t_hold_while_shifting(input logic [W-1:0] held, input logic [W-1:0] nxt);
    shift_word(nxt);
    check("R3 hold unchanged by shifts", {24'b0, par_o}, {24'b0, held});
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    check("R2 no shift without strobe", {24'b0, par_o}, {24'b0, nxt});
  endtask

  task automatic t_oe(input logic [W-1:0] held);
    @(negedge clk_i); oe_ni = 1'b1; #1;
    check("R6 disabled data", {24'b0, par_o}, 32'd0);
    check("R6 disabled flag", {31'b0, par_oe_o}, 32'd0);
    check("R7 ser_o ignores oe", {31'b0, ser_o}, {31'b0, held[W-1]});
    @(negedge clk_i); oe_ni = 1'b0; #1;
    check("R6 re-enabled data", {24'b0, par_o}, {24'b0, held});
  endtask

  task automatic t_same_cycle;
    shift_word(8'hC3);
    step(1'b1, 1'b1, 1'b1);
    check("R8 store sees pre-shift", {24'b0, par_o}, 32'hC3);
    step(1'b0, 1'b0, 1'b1);
    check("R8 shift still applied", {24'b0, par_o}, 32'h87);
  endtask

  task automatic t_async_reset;
    shift_word(8'h96);
    step(1'b0, 1'b0, 1'b1);
    shift_word(8'hFF);
    @(negedge clk_i); #1;
    rst_ni = 1'b0; #1;
    check("R4 ser_o clears without edge", {31'b0, ser_o}, 32'd0);
    check("R5 hold kept during reset", {24'b0, par_o}, 32'h96);
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    check("R4 stages zero after reset", {24'b0, par_o}, 32'd0);
  endtask

  task automatic t_cascade(input logic [2*W-1:0] v);
    for (int i = 2 * W - 1; i >= 0; i--) step(v[i], 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    check("R10 near block word", {24'b0, par_o}, {24'b0, v[W-1:0]});
    check("R10 far block word", {24'b0, par_b}, {24'b0, v[2*W-1:W]});
    check("R10 first bit at far H", {31'b0, ser_b}, {31'b0, v[2*W-1]});
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1;
    t_reset_state();
    @(negedge clk_i); rst_ni = 1'b1; rst_b = 1'b1;
    t_first_shift();
    t_shift_store(8'hA5);
    t_shift_store(8'h3C);
    t_hold_while_shifting(8'h3C, 8'h5A);
    t_oe(8'h5A);
    t_same_cycle();
    t_async_reset();
    t_cascade(16'hB1E4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule